// File: doc/BRIEF.md
# Condition Flag Update Unit

This block holds the four condition flags of a processor (negative, zero, carry, overflow) and refreshes them once an instruction completes. The execution stage tells it which class of operation finished. It also supplies the sign bits of the two adder operands, the result, the adder's carry-out and the shifter's carry-out. From these the unit works out the new flag values, following rules that depend on the operation class.

Comparison and test classes always update the flags. Ordinary data classes update them only when their flag-set enable is high. A flag-setting data operation that targets the program counter does not compute flags: it copies a saved status value into them, as an exception return does. A direct status-write port overrides everything else in the same cycle, and it also serves the load-status-from-memory return path.

The flags are registered. A one-cycle strobe marks every cycle in which they were loaded.

Top module: `flag_update_unit`

## Requirements
- R1: A synchronous active-high reset clears all four flags and the change strobe to 0, whatever the other inputs are doing. The flags bus is ordered {N,Z,C,V} on bits [3:0].
- R2: On a computed update, N takes bit DATA_W-1 of the result, and Z is 1 exactly when the whole result is zero.
- R3: For add classes (opClass 0 = add, 4 = compare-add), C takes the adder carry-out from the top bit.
- R4: For subtract classes (opClass 1 = subtract, 5 = compare-subtract), the adder forms a + ~b + 1. C takes its carry-out, so C is 0 on a borrow and 1 otherwise.
- R5: For add and subtract classes, V is 1 exactly on two's-complement signed overflow. For add this is (sa==sb)&&(sr!=sa); for subtract a-b it is (sa!=sb)&&(sr!=sa).
- R6: For shifted logical classes (opClass 2 = data, 6 = test), C takes the shifter carry-out and V keeps its previous value.
- R7: For plain logical classes (opClass 3 = data, 7 = test), C and V both keep their previous values.
- R8: Compare and test classes (opClass bit 2 set) update the flags on every valid operation, with flagSetEn ignored. Data classes update them only when flagSetEn is 1.
- R9: A valid data-class operation with flagSetEn=1 and destIsPc=1 loads savedFlags instead of the computed values. destIsPc has no effect on compare and test classes.
- R10: A direct write (directWrEn=1) loads directWrFlags. It takes priority over a saved-status restore and over a computed update in the same cycle.
- R11: When no update is selected, all four flags hold. flagsChanged is 1 for exactly the cycle after an update was selected, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opValid | input | 1 | An instruction completes this cycle |
| opClass | input | 3 | Operation class code (see R3 to R8) |
| flagSetEn | input | 1 | Flag-setting variant of a data operation |
| destIsPc | input | 1 | Destination register is the program counter |
| opASign | input | 1 | Sign bit of adder operand a |
| opBSign | input | 1 | Sign bit of adder operand b |
| aluResult | input | DATA_W | Operation result |
| aluCarryOut | input | 1 | Adder carry-out of the top bit |
| shiftCarryOut | input | 1 | Last bit shifted out by the shifter |
| savedFlags | input | 4 | Saved status flags {N,Z,C,V} |
| directWrEn | input | 1 | Direct status write enable |
| directWrFlags | input | 4 | Value for a direct write {N,Z,C,V} |
| flags | output | 4 | Current flags {N,Z,C,V} |
| flagsChanged | output | 1 | One-cycle strobe after any flag load |

## Verification
All results arrive exactly one clock edge after their stimulus: the new flags and the change strobe are both registered at the edge that samples the inputs. The bench applies each operation just after a falling edge, and it compares flags and flagsChanged at the next falling edge, which is one rising edge later. The next operation is applied in that same moment, so no stimulus stays applied for a second edge and no operation is counted twice. The bench builds the unit at a 4-bit datapath and sweeps every operand pair through the add and subtract classes. Its expected carry, overflow and zero come from integer arithmetic.

// File: rtl/flag_unit_pkg.sv
package flag_unit_pkg;

  localparam int NUM_FLAGS = 4;
  localparam int FLAG_N = 3;
  localparam int FLAG_Z = 2;
  localparam int FLAG_C = 1;
  localparam int FLAG_V = 0;

  typedef enum logic [2:0] {
    OP_ADD     = 3'd0,
    OP_SUB     = 3'd1,
    OP_LOG_SH  = 3'd2,
    OP_LOG     = 3'd3,
    OP_CMP_ADD = 3'd4,
    OP_CMP_SUB = 3'd5,
    OP_TST_SH  = 3'd6,
    OP_TST     = 3'd7
  } opClass_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic ldDirect;
    logic ldSaved;
    logic ldCompute;
    logic arith;
    logic subtract;
    logic shiftCarry;
  } flagStrobe_t;

endpackage

// File: rtl/flag_ctrl.sv
module flag_ctrl
  import flag_unit_pkg::*;
(
  input  logic        opValid,
  input  logic [2:0]  opClass,
  input  logic        flagSetEn,
  input  logic        destIsPc,
  input  logic        directWrEn,
  output flagStrobe_t strb
);

  opClass_e cls;
  logic isCompare;
  logic wantUpdate;
  logic wantRestore;

  always_comb begin
    cls         = opClass_e'(opClass);
    isCompare   = opClass[2];
    wantUpdate  = opValid && (isCompare || flagSetEn);
    wantRestore = opValid && !isCompare && flagSetEn && destIsPc;
  end

  always_comb begin
    strb            = '0;
    strb.ldDirect   = directWrEn;
    strb.ldSaved    = !directWrEn && wantRestore;
    strb.ldCompute  = !directWrEn && !wantRestore && wantUpdate;
    unique case (cls)
      OP_ADD, OP_CMP_ADD: begin
        strb.arith    = 1'b1;
        strb.subtract = 1'b0;
      end
      OP_SUB, OP_CMP_SUB: begin
        strb.arith    = 1'b1;
        strb.subtract = 1'b1;
      end
      OP_LOG_SH, OP_TST_SH: begin
        strb.shiftCarry = 1'b1;
      end
      OP_LOG, OP_TST: begin
        strb.shiftCarry = 1'b0;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/flag_datapath.sv
module flag_datapath
  import flag_unit_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  flagStrobe_t          strb,
  input  logic                 opASign,
  input  logic                 opBSign,
  input  logic [DATA_W-1:0]    aluResult,
  input  logic                 aluCarryOut,
  input  logic                 shiftCarryOut,
  input  logic [NUM_FLAGS-1:0] savedFlags,
  input  logic [NUM_FLAGS-1:0] directWrFlags,
  output logic [NUM_FLAGS-1:0] flags,
  output logic                 flagsChanged
);

  localparam int MSB = DATA_W - 1;

  logic                 resSign;
  logic                 resZero;
  logic                 addOvf;
  logic                 subOvf;
  logic [NUM_FLAGS-1:0] computed;
  logic [NUM_FLAGS-1:0] nextFlags;
  logic                 anyLoad;

  always_comb begin
    resSign = aluResult[MSB];
    resZero = (aluResult == '0);
    addOvf  = (opASign == opBSign) && (resSign != opASign);
    subOvf  = (opASign != opBSign) && (resSign != opASign);
  end

  always_comb begin
    computed         = flags;
    computed[FLAG_N] = resSign;
    computed[FLAG_Z] = resZero;
    if (strb.arith) begin
      computed[FLAG_C] = aluCarryOut;
      computed[FLAG_V] = strb.subtract ? subOvf : addOvf;
    end else if (strb.shiftCarry) begin
      computed[FLAG_C] = shiftCarryOut;
    end
  end

  always_comb begin
    anyLoad = strb.ldDirect || strb.ldSaved || strb.ldCompute;
    if (strb.ldDirect)       nextFlags = directWrFlags;
    else if (strb.ldSaved)   nextFlags = savedFlags;
    else if (strb.ldCompute) nextFlags = computed;
    else                     nextFlags = flags;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags        <= '0;
      flagsChanged <= 1'b0;
    end else begin
      flags        <= nextFlags;
      flagsChanged <= anyLoad;
    end
  end

endmodule

// File: rtl/flag_update_unit.sv
module flag_update_unit
  import flag_unit_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              opValid,
  input  logic [2:0]        opClass,
  input  logic              flagSetEn,
  input  logic              destIsPc,
  input  logic              opASign,
  input  logic              opBSign,
  input  logic [DATA_W-1:0] aluResult,
  input  logic              aluCarryOut,
  input  logic              shiftCarryOut,
  input  logic [3:0]        savedFlags,
  input  logic              directWrEn,
  input  logic [3:0]        directWrFlags,
  output logic [3:0]        flags,
  output logic              flagsChanged
);

  flagStrobe_t strb;

  flag_ctrl u_ctrl (
    .opValid    (opValid),
    .opClass    (opClass),
    .flagSetEn  (flagSetEn),
    .destIsPc   (destIsPc),
    .directWrEn (directWrEn),
    .strb       (strb)
  );

  flag_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk           (clk),
    .rst           (rst),
    .strb          (strb),
    .opASign       (opASign),
    .opBSign       (opBSign),
    .aluResult     (aluResult),
    .aluCarryOut   (aluCarryOut),
    .shiftCarryOut (shiftCarryOut),
    .savedFlags    (savedFlags),
    .directWrFlags (directWrFlags),
    .flags         (flags),
    .flagsChanged  (flagsChanged)
  );

endmodule

// File: rtl/flag_unit_checker.sv
module flag_unit_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              opValid,
  input logic [2:0]        opClass,
  input logic              flagSetEn,
  input logic              destIsPc,
  input logic              opASign,
  input logic              opBSign,
  input logic [DATA_W-1:0] aluResult,
  input logic              aluCarryOut,
  input logic              shiftCarryOut,
  input logic [3:0]        savedFlags,
  input logic              directWrEn,
  input logic [3:0]        directWrFlags,
  input logic [3:0]        flags,
  input logic              flagsChanged
);

  logic restoreSel;
  logic computeSel;
  logic arithSel;
  logic expOvf;

  always_comb begin
    restoreSel = !directWrEn && opValid && flagSetEn && destIsPc && !opClass[2];
    computeSel = !directWrEn && !restoreSel && opValid && (opClass[2] || flagSetEn);
    arithSel   = (opClass[1:0] == 2'b00) || (opClass[1:0] == 2'b01);
    expOvf     = opClass[0] ? ((opASign != opBSign) && (aluResult[DATA_W-1] != opASign))
                            : ((opASign == opBSign) && (aluResult[DATA_W-1] != opASign));
  end

  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (flags == 4'b0) && !flagsChanged);

  p_nz_r2: assert property (@(posedge clk) disable iff (rst)
    computeSel |=> (flags[3] == $past(aluResult[DATA_W-1])) &&
                   (flags[2] == ($past(aluResult) == '0)));

  p_carry_arith_r3: assert property (@(posedge clk) disable iff (rst)
    (computeSel && arithSel) |=> flags[1] == $past(aluCarryOut));

  p_overflow_r5: assert property (@(posedge clk) disable iff (rst)
    (computeSel && arithSel) |=> flags[0] == $past(expOvf));

  p_shift_carry_r6: assert property (@(posedge clk) disable iff (rst)
    (computeSel && opClass[1:0] == 2'b10) |=>
      (flags[1] == $past(shiftCarryOut)) && (flags[0] == $past(flags[0])));

  p_plain_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (computeSel && opClass[1:0] == 2'b11) |=> flags[1:0] == $past(flags[1:0]));

  p_restore_r9: assert property (@(posedge clk) disable iff (rst)
    restoreSel |=> (flags == $past(savedFlags)) && flagsChanged);

  p_direct_r10: assert property (@(posedge clk) disable iff (rst)
    directWrEn |=> (flags == $past(directWrFlags)) && flagsChanged);

  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (!directWrEn && !opValid) |=> !flagsChanged && $stable(flags));

endmodule

bind flag_update_unit flag_unit_checker #(.DATA_W(DATA_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .opValid       (opValid),
  .opClass       (opClass),
  .flagSetEn     (flagSetEn),
  .destIsPc      (destIsPc),
  .opASign       (opASign),
  .opBSign       (opBSign),
  .aluResult     (aluResult),
  .aluCarryOut   (aluCarryOut),
  .shiftCarryOut (shiftCarryOut),
  .savedFlags    (savedFlags),
  .directWrEn    (directWrEn),
  .directWrFlags (directWrFlags),
  .flags         (flags),
  .flagsChanged  (flagsChanged)
);

// File: tb/tb_flag_update_unit.sv
`timescale 1ns/1ps
module tb_flag_update_unit;

  localparam int W = 4;
  localparam int MAXV = 1 << W;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         opValid = 1'b0;
  logic [2:0]   opClass = 3'd0;
  logic         flagSetEn = 1'b0;
  logic         destIsPc = 1'b0;
  logic         opASign = 1'b0;
  logic         opBSign = 1'b0;
  logic [W-1:0] aluResult = '0;
  logic         aluCarryOut = 1'b0;
  logic         shiftCarryOut = 1'b0;
  logic [3:0]   savedFlags = 4'b0;
  logic         directWrEn = 1'b0;
  logic [3:0]   directWrFlags = 4'b0;
  logic [3:0]   flags;
  logic         flagsChanged;

  int nChecks = 0;
  int nFails  = 0;
  logic [3:0] expFlags = 4'b0;

  always #4 clk = ~clk;

  flag_update_unit #(.DATA_W(W)) dut (
    .clk(clk), .rst(rst), .opValid(opValid), .opClass(opClass),
    .flagSetEn(flagSetEn), .destIsPc(destIsPc), .opASign(opASign),
    .opBSign(opBSign), .aluResult(aluResult), .aluCarryOut(aluCarryOut),
    .shiftCarryOut(shiftCarryOut), .savedFlags(savedFlags),
    .directWrEn(directWrEn), .directWrFlags(directWrFlags),
    .flags(flags), .flagsChanged(flagsChanged)
  );

  task automatic check(input string req, input logic [3:0] expF, input logic expC);
    nChecks++;
    if (flags !== expF || flagsChanged !== expC) begin
      nFails++;
      $display("FAIL %s: flags=%b changed=%b expected flags=%b changed=%b",
               req, flags, flagsChanged, expF, expC);
    end
  endtask

  task automatic idle();
    opValid = 1'b0; directWrEn = 1'b0; flagSetEn = 1'b0; destIsPc = 1'b0;
  endtask

  // Apply at the current negedge, sample at the next one.
  task automatic stepCheck(input string req, input logic [3:0] expF, input logic expC);
    @(negedge clk);
    check(req, expF, expC);
  endtask

  task automatic directSet(input logic [3:0] v);
    idle();
    directWrEn = 1'b1; directWrFlags = v;
    stepCheck("R10", v, 1'b1);
    idle();
  endtask

  task automatic arithOp(input logic [2:0] cls, input logic fs, input int a, input int b);
    int sum;
    int sa, sb, sr;
    logic [W-1:0] r;
    logic co, ovf;
    logic [3:0] e;
    logic upd;
    logic isSub;
    isSub = cls[0];
    sum   = isSub ? (a + ((~b) & (MAXV - 1)) + 1) : (a + b);
    r     = W'(sum);
    co    = (sum >= MAXV);
    sa    = (a >= MAXV/2) ? a - MAXV : a;
    sb    = (b >= MAXV/2) ? b - MAXV : b;
    sr    = isSub ? sa - sb : sa + sb;
    ovf   = (sr > MAXV/2 - 1) || (sr < -(MAXV/2));
    opValid = 1'b1; directWrEn = 1'b0; opClass = cls; flagSetEn = fs; destIsPc = 1'b0;
    opASign = a[W-1]; opBSign = b[W-1]; aluResult = r; aluCarryOut = co;
    shiftCarryOut = ~co;
    upd = cls[2] || fs;
    e = upd ? {r[W-1], (r == 0), co, ovf} : expFlags;
    if (!upd)
      stepCheck("R8 data op without flagSetEn holds", e, 1'b0);
    else if (isSub)
      stepCheck("R4/R5/R2 subtract", e, 1'b1);
    else
      stepCheck("R3/R5/R2 add", e, 1'b1);
    expFlags = e;
  endtask

  task automatic logicOp(input logic [2:0] cls, input logic [W-1:0] r, input logic sc);
    logic [3:0] e;
    opValid = 1'b1; directWrEn = 1'b0; opClass = cls; flagSetEn = 1'b1; destIsPc = 1'b0;
    aluResult = r; shiftCarryOut = sc; aluCarryOut = ~sc;
    opASign = ~expFlags[0]; opBSign = expFlags[0];
    e = {r[W-1], (r == 0), (cls[1:0] == 2'b10) ? sc : expFlags[1], expFlags[0]};
    if (cls[1:0] == 2'b10) stepCheck("R6 shifted logical", e, 1'b1);
    else                   stepCheck("R7 plain logical", e, 1'b1);
    expFlags = e;
  endtask

  initial begin
    #(8 * 200000);
    nChecks++; nFails++;
    $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset state", 4'b0000, 1'b0);
    rst = 1'b0;
    directSet(4'b1111);
    expFlags = 4'b1111;
    // reset beats a direct write
    rst = 1'b1; directWrEn = 1'b1; directWrFlags = 4'b1010;
    stepCheck("R1 reset over direct write", 4'b0000, 1'b0);
    rst = 1'b0; idle();
    expFlags = 4'b0000;

    // Exhaustive add/subtract sweeps, data and compare classes
    for (int a = 0; a < MAXV; a++)
      for (int b = 0; b < MAXV; b++) begin
        arithOp(3'd0, 1'b1, a, b);
        arithOp(3'd1, 1'b1, a, b);
        arithOp(3'd4, 1'b0, a, b);
        arithOp(3'd5, 1'b0, a, b);
      end
    // Data ops without flagSetEn: no change (R8)
    for (int a = 0; a < MAXV; a += 3) begin
      arithOp(3'd0, 1'b0, a, 5);
      arithOp(3'd1, 1'b0, a, 7);
    end

    // Logical classes from each preset C/V
    for (int p = 0; p < 4; p++)
      for (int r = 0; r < MAXV; r++)
        for (int sc = 0; sc < 2; sc++) begin
          idle();
          directSet({2'b00, 2'(p)});
          expFlags = {2'b00, 2'(p)};
          logicOp(3'd2, W'(r), 1'(sc));
          logicOp(3'd3, W'(r), 1'(sc));
          logicOp(3'd6, W'(r), 1'(sc));
          logicOp(3'd7, W'(r), 1'(sc));
        end

    // Idle hold (R11)
    idle();
    stepCheck("R11 idle hold", expFlags, 1'b0);
    stepCheck("R11 strobe one cycle", expFlags, 1'b0);

    // Restore from saved (R9)
    opValid = 1'b1; opClass = 3'd0; flagSetEn = 1'b1; destIsPc = 1'b1;
    savedFlags = 4'b0110; aluResult = '0; aluCarryOut = 1'b1;
    stepCheck("R9 restore on flag-set PC write", 4'b0110, 1'b1);
    opClass = 3'd3; savedFlags = 4'b1001; aluResult = W'(1);
    stepCheck("R9 restore logical class", 4'b1001, 1'b1);
    // Non-flag-setting PC write: hold (R8)
    flagSetEn = 1'b0; savedFlags = 4'b0000;
    stepCheck("R8 PC write without flagSetEn holds", 4'b1001, 1'b0);
    // destIsPc ignored for compares (R9)
    opClass = 3'd5; flagSetEn = 1'b0; destIsPc = 1'b1; savedFlags = 4'b1111;
    opASign = 1'b0; opBSign = 1'b0; aluResult = '0; aluCarryOut = 1'b1;
    stepCheck("R9 compare ignores destIsPc", 4'b0110, 1'b1);

    // Direct write priority (R10)
    opClass = 3'd0; flagSetEn = 1'b1; destIsPc = 1'b1; savedFlags = 4'b1111;
    directWrEn = 1'b1; directWrFlags = 4'b0001;
    stepCheck("R10 direct over restore", 4'b0001, 1'b1);
    destIsPc = 1'b0; directWrFlags = 4'b1000;
    stepCheck("R10 direct over compute", 4'b1000, 1'b1);
    idle();
    stepCheck("R11 hold after direct", 4'b1000, 1'b0);

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule